// File: doc/BRIEF.md
# Memory-mapped serial port with interrupt masking

This block is a serial port that sits on a simple word-addressed register bus. Software writes a character to the transmit register. The block sends it as a frame: one low start bit, eight data bits least significant first, and one high stop bit. Each bit lasts the number of system clocks held in the divisor register. On the receive side, the block looks for a falling edge, confirms the start bit at mid-bit, samples the eight data bits and the stop bit, and then holds the character until software reads it.

A status word collects several conditions:
- ready flags for transmit and receive;
- the error flags (framing, break, both overruns) and an exception summary of them;
- the level of the clear-to-send input and a flag that records any change in it;
- a flag for a match on the end-of-packet character.

A control word holds one interrupt enable for each status condition. It also holds two line controls: request-to-send and a forced transmit break. The interrupt output is high while any enabled status condition is active. Writing the status register clears the sticky flags.

Top module: `sio_port`

## Requirements
- R1: After reset the status word reads 0x0060 (TX-empty bit 5 and TX-ready bit 6 set, every other bit zero), the control word reads 0, `irq` is low, `txLine` is high and `rtsOut` is low.
- R2: A write of a byte to word address 1 sends it on `txLine` as one low start bit, eight data bits least significant first and one high stop bit. Each bit lasts `divisor` clocks. `txLine` is high whenever nothing is being sent.
- R3: TX-ready (status bit 6) is low while the holding register is full. TX-empty (bit 5) is set only when both the holding register and the shifter are idle. A transmit write while TX-ready is low sets TX-overrun (bit 4), and that write is dropped.
- R4: A received frame sets RX-ready (bit 7). A read of word address 0 returns the character and clears RX-ready.
- R5: A frame that completes while RX-ready is set sets RX-overrun (bit 3) and leaves the stored character unchanged.
- R6: A stop bit sampled low sets framing error (bit 1). A frame whose data and stop bits are all low also sets break (bit 2). Exception (bit 8) is the OR of bits 0 to 4. Bit 0 always reads zero, because the block has no parity.
- R7: Any write to the status register (word address 2) clears bits 1, 2, 3, 4, 10 and 12. Any of those bits that is set by an event in the same cycle stays set.
- R8: `irq` is high exactly when some status bit is set together with its enable in the control word (word address 3). Control bits 0 to 8, 10 and 12 are enables. Bits 9 and 11 never raise `irq`.
- R9: Control bit 11 drives `rtsOut`. Control bit 9 holds `txLine` low. Writing 0 to the control word clears both and masks every interrupt.
- R10: `ctsIn` passes through a two-flop synchroniser. Status bit 11 shows the synchronised level, and bit 10 is set on any change of that level.
- R11: Status bit 12 is set when a byte equal to the end-of-packet register (word address 5) is accepted for transmit or is received.
- R12: The divisor register (word address 4, 16 bits, reset value 16, minimum 2) and the end-of-packet register read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Word address of the register |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe; a read of word 0 consumes the character |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr`, combinational |
| irq | output | 1 | Interrupt request |
| txLine | output | 1 | Serial transmit line |
| rxLine | input | 1 | Serial receive line |
| ctsIn | input | 1 | Clear-to-send input, asynchronous |
| rtsOut | output | 1 | Request-to-send output |

## Verification
A transmit counter or shift register that has lost step shows up within one frame. The bench samples `txLine` at mid-bit, so a bit shifted in time or a wrong data order gives a wrong character or stop level. A receive sampler that is off by more than half a bit puts a wrong byte, or a spurious framing or break flag, into the status and data registers once the frame ends. Flag bookkeeping errors can be seen on the next bus read or directly on `irq`: a lost overrun, a stored character that was overwritten, a flag that is not cleared or is cleared too broadly. Synchroniser depth shows as the cycle in which status bit 11 first changes.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = 16;
  localparam int DIV_W  = 16;
  localparam int CHAR_W = 8;
  localparam int STAT_W = 13;
  localparam logic [DIV_W-1:0] DIV_RESET = 16;

  // word addresses
  localparam logic [ADDR_W-1:0] SEL_RX   = 3'd0;
  localparam logic [ADDR_W-1:0] SEL_TX   = 3'd1;
  localparam logic [ADDR_W-1:0] SEL_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] SEL_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] SEL_DIV  = 3'd4;
  localparam logic [ADDR_W-1:0] SEL_PKT  = 3'd5;

  // status / control bit positions (control enables share the status position)
  localparam int B_PERR  = 0;
  localparam int B_FERR  = 1;
  localparam int B_BRK   = 2;
  localparam int B_ROVR  = 3;
  localparam int B_TOVR  = 4;
  localparam int B_TEMPT = 5;
  localparam int B_TRDY  = 6;
  localparam int B_RRDY  = 7;
  localparam int B_EXC   = 8;
  localparam int B_FBRK  = 9;
  localparam int B_CTSCH = 10;
  localparam int B_CTS   = 11;
  localparam int B_RTS   = 11;
  localparam int B_PKT   = 12;

  localparam logic [STAT_W-1:0] IRQ_ENABLES = 13'h15FF;

  typedef struct packed {
    logic              txWrite;
    logic [CHAR_W-1:0] txByte;
    logic [DIV_W-1:0]  divisor;
    logic              forceBrk;
  } sioCmd_t;
endpackage

// File: rtl/sio_shift.sv
module sio_shift
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  sioCmd_t           cmd,
  input  logic              rxLine,
  output logic              txLine,
  output logic              holdFull,
  output logic              shiftBusy,
  output logic              rxValid,
  output logic [CHAR_W-1:0] rxByte,
  output logic              rxFrameErr,
  output logic              rxBreak
);
  localparam int FRAME_BITS = CHAR_W + 2;
  localparam int BITS_W     = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(CHAR_W);
  localparam logic [DIV_W-1:0] ONE = 1;

  // ---------------- transmit ----------------
  logic [CHAR_W-1:0]     holdByte;
  logic [FRAME_BITS-1:0] txShift;
  logic [BITS_W-1:0]     txBits;
  logic [DIV_W-1:0]      txCnt;

  assign shiftBusy = (txBits != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdByte <= '0;
      holdFull <= 1'b0;
      txShift  <= '1;
      txBits   <= '0;
      txCnt    <= '0;
    end else begin
      if (cmd.txWrite && !holdFull) begin
        holdByte <= cmd.txByte;
        holdFull <= 1'b1;
      end
      if (!shiftBusy) begin
        if (holdFull) begin
          txShift  <= {1'b1, holdByte, 1'b0};
          txBits   <= BITS_W'(FRAME_BITS);
          txCnt    <= cmd.divisor - ONE;
          holdFull <= 1'b0;
        end
      end else if (txCnt == '0) begin
        txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
        txBits  <= txBits - BITS_W'(1);
        txCnt   <= cmd.divisor - ONE;
      end else begin
        txCnt <= txCnt - ONE;
      end
    end
  end

  assign txLine = cmd.forceBrk ? 1'b0 : (shiftBusy ? txShift[0] : 1'b1);

  assert_tx_idle_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!shiftBusy && !cmd.forceBrk) |-> txLine);
  assert_force_break_R9: assert property (@(posedge clk) disable iff (!rstN)
    cmd.forceBrk |-> !txLine);

  // ---------------- receive ----------------
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rxState_t;
  rxState_t          rxState;
  logic [1:0]        rxSync;
  logic              rxS;
  logic [DIV_W-1:0]  rxCnt;
  logic [IDX_W-1:0]  rxIdx;
  logic [CHAR_W-1:0] rxShift;

  assign rxS = rxSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSync     <= 2'b11;
      rxState    <= RX_IDLE;
      rxCnt      <= '0;
      rxIdx      <= '0;
      rxShift    <= '0;
      rxValid    <= 1'b0;
      rxByte     <= '0;
      rxFrameErr <= 1'b0;
      rxBreak    <= 1'b0;
    end else begin
      rxSync  <= {rxSync[0], rxLine};
      rxValid <= 1'b0;
      case (rxState)
        RX_IDLE: if (!rxS) begin
          rxState <= RX_START;
          rxCnt   <= (cmd.divisor >> 1) - ONE;
        end
        RX_START: if (rxCnt == '0) begin
          if (rxS) rxState <= RX_IDLE;
          else begin
            rxState <= RX_DATA;
            rxCnt   <= cmd.divisor - ONE;
            rxIdx   <= '0;
          end
        end else rxCnt <= rxCnt - ONE;
        RX_DATA: if (rxCnt == '0) begin
          rxShift <= {rxS, rxShift[CHAR_W-1:1]};
          rxCnt   <= cmd.divisor - ONE;
          rxIdx   <= rxIdx + IDX_W'(1);
          if (rxIdx == IDX_W'(CHAR_W - 1)) rxState <= RX_STOP;
        end else rxCnt <= rxCnt - ONE;
        RX_STOP: if (rxCnt == '0) begin
          rxValid    <= 1'b1;
          rxByte     <= rxShift;
          rxFrameErr <= !rxS;
          rxBreak    <= !rxS && (rxShift == '0);
          rxState    <= rxS ? RX_IDLE : RX_WAITHI;
        end else rxCnt <= rxCnt - ONE;
        RX_WAITHI: if (rxS) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  assert_break_implies_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |-> (rxFrameErr && rxByte == '0));
endmodule

// File: rtl/sio_regs.sv
module sio_regs
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output logic              rtsOut,
  input  logic              ctsIn,
  output sioCmd_t           cmd,
  input  logic              holdFull,
  input  logic              shiftBusy,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxByte,
  input  logic              rxFrameErr,
  input  logic              rxBreak
);
  logic wrTx, wrStat, wrCtrl, wrDiv, wrPkt, rdRx;
  assign wrTx   = busWr && (busAddr == SEL_TX);
  assign wrStat = busWr && (busAddr == SEL_STAT);
  assign wrCtrl = busWr && (busAddr == SEL_CTRL);
  assign wrDiv  = busWr && (busAddr == SEL_DIV);
  assign wrPkt  = busWr && (busAddr == SEL_PKT);
  assign rdRx   = busRd && (busAddr == SEL_RX);

  logic [CHAR_W-1:0] rxBuf, pktChar;
  logic [STAT_W-1:0] ctrlReg;
  logic [DIV_W-1:0]  divReg;
  logic rxReady, ferrF, brkF, roeF, toeF, ctsChg, pktSeen;
  logic [1:0] ctsSync;
  logic ctsPrev;
  logic txAccept, keepReady;

  assign txAccept  = wrTx && !holdFull;
  assign keepReady = rxReady && !rdRx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf   <= '0;
      pktChar <= '0;
      ctrlReg <= '0;
      divReg  <= DIV_RESET;
      rxReady <= 1'b0;
      ferrF   <= 1'b0;
      brkF    <= 1'b0;
      roeF    <= 1'b0;
      toeF    <= 1'b0;
      ctsChg  <= 1'b0;
      pktSeen <= 1'b0;
      ctsSync <= 2'b00;
      ctsPrev <= 1'b0;
    end else begin
      ctsSync <= {ctsSync[0], ctsIn};
      ctsPrev <= ctsSync[1];
      if (wrCtrl) ctrlReg <= busWdata[STAT_W-1:0];
      if (wrDiv)  divReg  <= busWdata[DIV_W-1:0];
      if (wrPkt)  pktChar <= busWdata[CHAR_W-1:0];
      // sticky flags: a status write clears, a same-cycle event wins
      if (wrStat) begin
        ferrF <= 1'b0; brkF <= 1'b0; roeF <= 1'b0;
        toeF <= 1'b0; ctsChg <= 1'b0; pktSeen <= 1'b0;
      end
      if (rxValid) begin
        if (keepReady) roeF <= 1'b1;
        else begin
          rxBuf   <= rxByte;
          rxReady <= 1'b1;
        end
        if (rxFrameErr) ferrF <= 1'b1;
        if (rxBreak)    brkF  <= 1'b1;
        if (rxByte == pktChar) pktSeen <= 1'b1;
      end else if (rdRx) begin
        rxReady <= 1'b0;
      end
      if (wrTx && holdFull) toeF <= 1'b1;
      if (txAccept && busWdata[CHAR_W-1:0] == pktChar) pktSeen <= 1'b1;
      if (ctsSync[1] != ctsPrev) ctsChg <= 1'b1;
    end
  end

  logic [STAT_W-1:0] statWord;
  logic excF;
  assign excF = ferrF | brkF | roeF | toeF;
  always_comb begin
    statWord          = '0;
    statWord[B_PERR]  = 1'b0;
    statWord[B_FERR]  = ferrF;
    statWord[B_BRK]   = brkF;
    statWord[B_ROVR]  = roeF;
    statWord[B_TOVR]  = toeF;
    statWord[B_TEMPT] = !holdFull && !shiftBusy;
    statWord[B_TRDY]  = !holdFull;
    statWord[B_RRDY]  = rxReady;
    statWord[B_EXC]   = excF;
    statWord[B_CTSCH] = ctsChg;
    statWord[B_CTS]   = ctsSync[1];
    statWord[B_PKT]   = pktSeen;
  end

  assign irq    = |(statWord & ctrlReg & IRQ_ENABLES);
  assign rtsOut = ctrlReg[B_RTS];

  assign cmd.txWrite  = txAccept;
  assign cmd.txByte   = busWdata[CHAR_W-1:0];
  assign cmd.divisor  = divReg;
  assign cmd.forceBrk = ctrlReg[B_FBRK];

  always_comb begin
    case (busAddr)
      SEL_RX:   busRdata = BUS_W'(rxBuf);
      SEL_STAT: busRdata = BUS_W'(statWord);
      SEL_CTRL: busRdata = BUS_W'(ctrlReg);
      SEL_DIV:  busRdata = BUS_W'(divReg);
      SEL_PKT:  busRdata = BUS_W'(pktChar);
      default:  busRdata = '0;
    endcase
  end

  assert_rx_overrun_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && keepReady) |=> (roeF && rxBuf == $past(rxBuf)));
  assert_tx_overrun_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrTx && holdFull) |=> (toeF && holdFull));
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg == '0) |-> !irq);
  assert_break_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |=> (brkF && ferrF));
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irq,
  output logic              txLine,
  input  logic              rxLine,
  input  logic              ctsIn,
  output logic              rtsOut
);
  sioCmd_t           cmd;
  logic              holdFull, shiftBusy, rxValid, rxFrameErr, rxBreak;
  logic [CHAR_W-1:0] rxByte;

  sio_regs uRegs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq), .rtsOut(rtsOut),
    .ctsIn(ctsIn), .cmd(cmd), .holdFull(holdFull), .shiftBusy(shiftBusy),
    .rxValid(rxValid), .rxByte(rxByte), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );

  sio_shift uShift (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxLine(rxLine), .txLine(txLine),
    .holdFull(holdFull), .shiftBusy(shiftBusy), .rxValid(rxValid),
    .rxByte(rxByte), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak)
  );
endmodule

// File: tb/sio_port_test.sv
module sio_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        irq, txLine, rtsOut;
  logic        rxLine = 1'b1, ctsIn = 1'b0;

  int nChecks = 0, nBad = 0, cyc = 0;
  bit finished = 0;

  sio_port uut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .irq(irq),
    .txLine(txLine), .rxLine(rxLine), .ctsIn(ctsIn), .rtsOut(rtsOut));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input int sel, input int data);
    @(negedge clk); busAddr = 3'(sel); busWdata = 16'(data); busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    @(negedge clk);
  endtask

  task automatic busRead(input int sel, output int data);
    @(negedge clk); busAddr = 3'(sel); busRd = 1'b1;
    #1 data = int'(busRdata);
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b, input logic stopLvl);
    @(negedge clk); rxLine = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (DIV) @(negedge clk);
    end
    rxLine = stopLvl;
    repeat (DIV) @(negedge clk);
    rxLine = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic captureTx(output logic [7:0] b, output logic startLvl, output logic stopLvl);
    while (txLine) @(negedge clk);
    repeat (DIV/2) @(negedge clk);
    startLvl = txLine;
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = txLine;
    end
    repeat (DIV) @(negedge clk);
    stopLvl = txLine;
  endtask

  task automatic testReset;
    int d;
    busRead(2, d); checkEq("R1 status after reset", d, 'h60);
    busRead(3, d); checkEq("R1 control after reset", d, 0);
    checkEq("R1 irq after reset", irq, 0);
    checkEq("R1 txLine idle", txLine, 1);
    checkEq("R1 rtsOut after reset", rtsOut, 0);
  endtask

  task automatic testDivisor;
    int d;
    busRead(4, d); checkEq("R12 divisor reset value", d, 16);
    busWrite(4, DIV);
    busRead(4, d); checkEq("R12 divisor readback", d, DIV);
  endtask

  task automatic testTx;
    logic [7:0] b; logic s0, s1;
    busWrite(1, 'hA5);
    captureTx(b, s0, s1);
    checkEq("R2 start bit low", s0, 0);
    checkEq("R2 data byte", b, 'hA5);
    checkEq("R2 stop bit high", s1, 1);
    repeat (10) @(negedge clk);
    checkEq("R2 idle high after frame", txLine, 1);
  endtask

  task automatic testTxFlags;
    int d, t0, lows;
    logic [7:0] b; logic s0, s1;
    busWrite(1, 'h11);
    t0 = cyc;
    busWrite(1, 'h22);
    busRead(2, d);
    checkEq("R3 ready and empty low while holding", d & 'h60, 0);
    busWrite(1, 'h33);
    busRead(2, d);
    checkEq("R3 tx overrun and exception", d & 'h110, 'h110);
    while (cyc < t0 + 76) @(negedge clk);
    captureTx(b, s0, s1);
    checkEq("R3 held byte sent second", b, 'h22);
    repeat (10) @(negedge clk);
    busRead(2, d);
    checkEq("R3 ready and empty when idle", d & 'h60, 'h60);
    lows = 0;
    repeat (120) begin @(negedge clk); if (!txLine) lows++; end
    checkEq("R3 dropped write never sent", lows, 0);
    busWrite(2, 0);
  endtask

  task automatic testRx;
    int d;
    sendRx('h3C, 1'b1);
    busRead(2, d); checkEq("R4 rx ready set", d, 'hE0);
    busRead(0, d); checkEq("R4 rx data", d, 'h3C);
    busRead(2, d); checkEq("R4 rx ready cleared by read", d & 'h80, 0);
  endtask

  task automatic testRxOverrun;
    int d;
    sendRx('h41, 1'b1);
    sendRx('h42, 1'b1);
    busRead(2, d); checkEq("R5 overrun, exception, ready", d & 'h188, 'h188);
    busRead(0, d); checkEq("R5 old character kept", d, 'h41);
    busWrite(2, 0);
    busRead(2, d); checkEq("R7 status write clears flags", d, 'h60);
  endtask

  task automatic testFraming;
    int d;
    sendRx('h55, 1'b0);
    busRead(2, d); checkEq("R6 framing error without break", d & 'h107, 'h102);
    busRead(0, d);
    busWrite(2, 0);
    sendRx('h00, 1'b0);
    busRead(2, d); checkEq("R6 break plus framing", d & 'h107, 'h106);
    busRead(0, d);
    busWrite(2, 0);
    busRead(2, d); checkEq("R7 break and framing cleared", d, 'h60);
  endtask

  task automatic testIrqLines;
    int d;
    busWrite(3, 'h80);
    checkEq("R8 irq low with rx enabled but empty", irq, 0);
    sendRx('h7E, 1'b1);
    checkEq("R8 irq high on enabled rx ready", irq, 1);
    busRead(0, d);
    @(negedge clk);
    checkEq("R8 irq low after read", irq, 0);
    busWrite(3, 'h40);
    checkEq("R8 irq on enabled tx ready", irq, 1);
    busWrite(3, 'hA00);
    checkEq("R8 line-control bits do not raise irq", irq, 0);
    checkEq("R9 break forces txLine low", txLine, 0);
    checkEq("R9 rts driven", rtsOut, 1);
    busWrite(3, 0);
    checkEq("R9 rts cleared by zero write", rtsOut, 0);
    checkEq("R9 break released by zero write", txLine, 1);
  endtask

  task automatic testCts;
    int d;
    @(negedge clk); ctsIn = 1'b1;
    @(negedge clk);
    busAddr = 3'd2; #1 checkEq("R10 level not through after one edge", (busRdata >> 11) & 1, 0);
    @(negedge clk);
    #1 checkEq("R10 level through after two edges", (busRdata >> 11) & 1, 1);
    repeat (3) @(negedge clk);
    busRead(2, d); checkEq("R10 change flag and level", d & 'hC00, 'hC00);
    busWrite(2, 0);
    busRead(2, d); checkEq("R7 change flag cleared, level kept", d & 'hC00, 'h800);
    busWrite(3, 'h400);
    checkEq("R8 irq low before cts change", irq, 0);
    @(negedge clk); ctsIn = 1'b0;
    repeat (4) @(negedge clk);
    checkEq("R10 irq on cts change", irq, 1);
    busWrite(3, 0);
    busWrite(2, 0);
  endtask

  task automatic testPkt;
    int d;
    busWrite(5, 'h0A);
    busRead(5, d); checkEq("R12 packet char readback", d, 'h0A);
    busRead(2, d); checkEq("R11 flag clear before match", d & 'h1000, 0);
    busWrite(1, 'h0A);
    busRead(2, d); checkEq("R11 flag on tx match", d & 'h1000, 'h1000);
    repeat (100) @(negedge clk);
    busWrite(2, 0);
    sendRx('h0B, 1'b1);
    busRead(2, d); checkEq("R11 no flag on mismatch", d & 'h1000, 0);
    busRead(0, d);
    sendRx('h0A, 1'b1);
    busRead(2, d); checkEq("R11 flag on rx match", d & 'h1000, 'h1000);
    busRead(0, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset;
    testDivisor;
    testTx;
    testTxFlags;
    testRx;
    testRxOverrun;
    testFraming;
    testIrqLines;
    testCts;
    testPkt;
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule